// File: doc/BRIEF.md
# PHY Control Register Bank with Set/Clear Aliases

This block is the byte-wide register bank that a USB transceiver exposes to its link controller through a simple address, write-data and read-data port. It holds four read-only identity bytes, three control registers (function control, interface control and OTG control) and one free scratch byte. The control registers drive the transceiver's operating mode straight from their output ports.

Each control register is reached at three consecutive addresses: a plain read/write address, a write-1-to-set alias and a write-1-to-clear alias. The aliases have no storage of their own. They let software change single bits without a read-modify-write. Two interface-control mode bits also drop back to zero by themselves when the hardware reports that the matching mode has been left.

Reads are registered: the byte addressed in a cycle with `rd_en` high appears on `rd_data` one clock later, together with `rd_valid`.

Top module: `phy_ctrl_regs`

## Requirements
- R1: After reset, function control reads 0x41, interface control 0x00, OTG control 0x06 and scratch 0x00.
- R2: Addresses 0x00, 0x01, 0x02 and 0x03 read 0x51, 0x04, 0x07 and 0x15 (vendor 0x0451 and product 0x1507, low byte first). Writes to them are ignored.
- R3: A write to a base address (0x04 function, 0x07 interface, 0x0A OTG) replaces the register. Function-control bit 7 is reserved: it ignores writes and always reads 0.
- R4: A write to a set alias (0x05, 0x08, 0x0B) sets every bit written as 1. Bits written as 0 keep their value.
- R5: A write to a clear alias (0x06, 0x09, 0x0C) clears every bit written as 1. Bits written as 0 keep their value.
- R6: A read of a set or clear alias returns the current value of the register behind it.
- R7: A pulse on `uart_exit` clears interface-control bit 2, and a pulse on `serial_exit` clears bit 1. Other bits are left unchanged. When such a pulse comes in the same cycle as a write that would set the bit, the clear wins.
- R8: The scratch byte at 0x16 is fully read/write, and writing it changes no other register.
- R9: An unmapped address reads 0x00, and a write to it changes no register.
- R10: `rd_valid` and `rd_data` follow `rd_en` by exactly one clock. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read byte, one clock after rd_en |
| rd_valid | output | 1 | rd_data is valid |
| uart_exit | input | 1 | Hardware left UART mode |
| serial_exit | input | 1 | Hardware left 3-pin serial mode |
| func_ctrl | output | 8 | Function control register |
| ifc_ctrl | output | 8 | Interface control register |
| otg_ctrl | output | 8 | OTG control register |

## Verification
The hardest case to reach is a mode-exit pulse that lands in the same clock as a set-alias write to the same interface-control bit. Only a correct priority between the two keeps the bit at zero. The bench raises `uart_exit` in the very cycle it writes 0x06 to the set alias 0x08. It then expects bit 2 cleared and bit 1 set. A second corner is a read and a write to the scratch byte in one cycle, which must return the old value.

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs #(
  parameter int          AW         = 8,
  parameter logic [15:0] VENDOR_ID  = 16'h0451,
  parameter logic [15:0] PRODUCT_ID = 16'h1507
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  input  logic          uart_exit,
  input  logic          serial_exit,
  output logic [7:0]    func_ctrl,
  output logic [7:0]    ifc_ctrl,
  output logic [7:0]    otg_ctrl
);
  localparam logic [AW-1:0] A_FUNC    = AW'(8'h04);
  localparam logic [AW-1:0] A_IFC     = AW'(8'h07);
  localparam logic [AW-1:0] A_OTG     = AW'(8'h0A);
  localparam logic [AW-1:0] A_SCRATCH = AW'(8'h16);
  localparam logic [7:0] FUNC_RST  = 8'h41;
  localparam logic [7:0] FUNC_MASK = 8'h7F;
  localparam logic [7:0] OTG_RST   = 8'h06;

  function automatic logic [1:0] op_of(input logic [AW-1:0] a, input logic [AW-1:0] base);
    if (a == base)                 return 2'd1;
    if (a == base + AW'(1))        return 2'd2;
    if (a == base + AW'(2))        return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [7:0] apply(input logic [7:0] cur, input logic [1:0] op, input logic [7:0] d);
    case (op)
      2'd1:    return d;
      2'd2:    return cur | d;
      2'd3:    return cur & ~d;
      default: return cur;
    endcase
  endfunction

  logic [1:0] fop, iop, oop;
  logic [7:0] scratch, rd_mux, exit_mask;

  assign fop = wr_en ? op_of(addr, A_FUNC) : 2'd0;
  assign iop = wr_en ? op_of(addr, A_IFC)  : 2'd0;
  assign oop = wr_en ? op_of(addr, A_OTG)  : 2'd0;
  assign exit_mask = {5'b0, uart_exit, serial_exit, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      func_ctrl <= FUNC_RST;
      ifc_ctrl  <= 8'h00;
      otg_ctrl  <= OTG_RST;
      scratch   <= 8'h00;
    end else begin
      func_ctrl <= apply(func_ctrl, fop, wr_data) & FUNC_MASK;
      ifc_ctrl  <= apply(ifc_ctrl, iop, wr_data) & ~exit_mask;
      otg_ctrl  <= apply(otg_ctrl, oop, wr_data);
      if (wr_en && addr == A_SCRATCH) scratch <= wr_data;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (addr == AW'(0))      rd_mux = VENDOR_ID[7:0];
    else if (addr == AW'(1)) rd_mux = VENDOR_ID[15:8];
    else if (addr == AW'(2)) rd_mux = PRODUCT_ID[7:0];
    else if (addr == AW'(3)) rd_mux = PRODUCT_ID[15:8];
    else if (op_of(addr, A_FUNC) != 2'd0) rd_mux = func_ctrl;
    else if (op_of(addr, A_IFC)  != 2'd0) rd_mux = ifc_ctrl;
    else if (op_of(addr, A_OTG)  != 2'd0) rd_mux = otg_ctrl;
    else if (addr == A_SCRATCH)  rd_mux = scratch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

module phy_ctrl_regs_chk #(parameter int AW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          uart_exit,
  input logic          serial_exit,
  input logic [7:0]    func_ctrl,
  input logic [7:0]    ifc_ctrl,
  input logic [7:0]    otg_ctrl
);
  AST_FUNC_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h05)) |=> ((func_ctrl & $past(wr_data) & 8'h7F) == ($past(wr_data) & 8'h7F))); // R4
  AST_OTG_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h0C)) |=> ((otg_ctrl & $past(wr_data)) == 8'h00)); // R5
  AST_ZERO_SET_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h0B) && wr_data == 8'h00) |=> $stable(otg_ctrl)); // R4
  AST_UART_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    uart_exit |=> !ifc_ctrl[2]); // R7
  AST_SERIAL_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    serial_exit |=> !ifc_ctrl[1]); // R7
  AST_SCRATCH_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h16)) |=> ($stable(func_ctrl) && $stable(ifc_ctrl) && $stable(otg_ctrl))); // R8
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R10
endmodule

bind phy_ctrl_regs phy_ctrl_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_valid(rd_valid), .uart_exit(uart_exit),
  .serial_exit(serial_exit), .func_ctrl(func_ctrl), .ifc_ctrl(ifc_ctrl),
  .otg_ctrl(otg_ctrl)
);

// File: tb/phy_ctrl_regs_bench.sv
module phy_ctrl_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic       uart_exit = 1'b0;
  logic       serial_exit = 1'b0;
  logic [7:0] rd_data, func_ctrl, ifc_ctrl, otg_ctrl;
  logic       rd_valid;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  phy_ctrl_regs u_phy_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .uart_exit(uart_exit), .serial_exit(serial_exit),
    .func_ctrl(func_ctrl), .ifc_ctrl(ifc_ctrl), .otg_ctrl(otg_ctrl)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 actual=unexpected read expected=none");
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 func", func_ctrl, 8'h41);
    check("R1 ifc", ifc_ctrl, 8'h00);
    check("R1 otg", otg_ctrl, 8'h06);
    rd(8'h16, 8'h00, "R1 scratch");
    rd(8'h00, 8'h51, "R2 id0");
    rd(8'h01, 8'h04, "R2 id1");
    rd(8'h02, 8'h07, "R2 id2");
    rd(8'h03, 8'h15, "R2 id3");
    wr(8'h02, 8'hAA);
    rd(8'h02, 8'h07, "R2 write ignored");
    wr(8'h04, 8'hFF);
    check("R3 func reserved bit", func_ctrl, 8'h7F);
    wr(8'h04, 8'h12);
    rd(8'h04, 8'h12, "R3 func write");
    wr(8'h0A, 8'h81);
    check("R3 otg write", otg_ctrl, 8'h81);
    wr(8'h05, 8'h0C);
    check("R4 func set", func_ctrl, 8'h1E);
    wr(8'h0B, 8'h00);
    check("R4 zero set no effect", otg_ctrl, 8'h81);
    wr(8'h06, 8'h10);
    check("R5 func clr", func_ctrl, 8'h0E);
    wr(8'h0C, 8'h00);
    check("R5 zero clr no effect", otg_ctrl, 8'h81);
    wr(8'h0C, 8'h01);
    check("R5 otg clr", otg_ctrl, 8'h80);
    rd(8'h05, 8'h0E, "R6 read set alias");
    rd(8'h0C, 8'h80, "R6 read clr alias");
    wr(8'h07, 8'hF7);
    wr(8'h09, 8'hF0);
    rd(8'h08, 8'h07, "R6 ifc via set alias");
    @(negedge clk); uart_exit = 1'b1;
    @(negedge clk); uart_exit = 1'b0;
    check("R7 uart exit", ifc_ctrl, 8'h03);
    @(negedge clk); serial_exit = 1'b1;
    @(negedge clk); serial_exit = 1'b0;
    check("R7 serial exit", ifc_ctrl, 8'h01);
    @(negedge clk);
    addr = 8'h08; wr_data = 8'h06; wr_en = 1'b1; uart_exit = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; uart_exit = 1'b0;
    check("R7 exit beats set", ifc_ctrl, 8'h03);
    wr(8'h16, 8'h5A);
    rd(8'h16, 8'h5A, "R8 scratch rw");
    check("R8 func untouched", func_ctrl, 8'h0E);
    check("R8 otg untouched", otg_ctrl, 8'h80);
    wr(8'h30, 8'hFF);
    rd(8'h30, 8'h00, "R9 unmapped read");
    check("R9 ifc untouched", ifc_ctrl, 8'h03);
    @(negedge clk);
    addr = 8'h16; wr_data = 8'hC3; wr_en = 1'b1; rd_en = 1'b1;
    exp_q.push_back(8'h5A); tag_q.push_back("R10 read before write");
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    rd(8'h16, 8'hC3, "R10 write landed");
    repeat (3) @(negedge clk);
    check("R10 reads drained", 8'(exp_q.size()), 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule